// File: doc/BRIEF.md
# Counter-Based Microprogram Control Unit

This block is a small microprogrammed controller joined to an 8-bit accumulator datapath. A microprogram counter addresses an on-chip microcode store. Each 16-bit microword is either an ALU operation on the accumulator, a conditional branch, an unconditional jump or a halt. Before a run, the store is filled through a write port. While that port is active, execution is frozen.

There is no pipeline register. The fetch from the store and the execution of the fetched word share one clock cycle. The accumulator, the status flags and the counter all change on the rising edge that closes that cycle.

A conditional branch does no ALU work. It tests flags that are already registered, which are the flags left by the instruction before it. When the test passes, the branch address from the microword enters the counter on the next edge through a synchronous load.

Microword layout:
- Bits [15:14] hold the class: 00 ALU, 01 conditional branch, 10 jump, 11 halt.
- Bits [13:12] hold the condition select.
- Bits [11:9] hold the ALU operation.
- Bit [8] selects the operand source.
- Bits [7:0] hold the branch target or the immediate value.

Top module: `mcu_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `upc_o` to 0, `acc_o` to 0 and all three flags to 0. Reset takes priority over the write port.
- R2: An ALU-class word (bits [15:14] = 00) moves `upc_o` to its current value plus one on the next edge. The counter wraps from 255 to 0.
- R3: A conditional-branch word (bits [15:14] = 01) selects its condition with bits [13:12]: 00 always, 01 zero, 10 carry, 11 negative. The test uses the flags registered before this word.
  - If the condition is true, `upc_o` takes bits [7:0] on the next edge.
  - Otherwise `upc_o` increments.
  - Either way the branch takes exactly one cycle.
- R4: A jump word (bits [15:14] = 10) loads bits [7:0] into `upc_o` on the next edge, whatever bits [13:12] hold.
- R5: Conditional-branch and jump words leave `acc_o` and all flags unchanged.
- R6: A halt word (bits [15:14] = 11) keeps `upc_o`, `acc_o` and the flags unchanged on every following edge.
- R7: While `ucode_we` is high, `upc_o`, `acc_o` and the flags hold their values.
- R8: A word written at an address through the write port is the one executed when the counter next holds that address.
- R9: An ALU word uses operation bits [11:9] and source bit [8]. Operations are: 000 pass, 001 add, 010 subtract (accumulator minus operand), 011 AND, 100 OR, 101 XOR. The source is 0 for `opnd_i` and 1 for the immediate in bits [7:0]. The 8-bit result is written to `acc_o` on the edge that ends the cycle.
- R10: On every ALU word, `zero_o` becomes (result == 0) and `neg_o` becomes result bit 7, on the same edge as `acc_o`. `carry_o` changes only on add and subtract:
  - On add it takes the carry out.
  - On subtract it takes the borrow, which is 1 when the accumulator is below the operand.
  - On every other ALU operation it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ucode_we | input | 1 | Microcode write enable; freezes execution while high |
| ucode_addr | input | 8 | Microcode write address |
| ucode_data | input | 16 | Microcode word to write |
| opnd_i | input | 8 | External ALU operand |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry/borrow flag |
| neg_o | output | 1 | Negative flag |
| upc_o | output | 8 | Current microprogram address |

## Verification
Every result of this block is due exactly one rising edge after the microword is presented: the accumulator, the flags and the next address. The bench therefore drives the external operand just after an edge, advances one edge, and samples one time unit later.

A taken branch is checked by finding its target in `upc_o` after that single edge. The word stored at the target is then checked on the edge after that.

The flag-dependent branches read flags that were settled one edge earlier. The expected values for them are worked out from the previous row of the trace.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

   localparam int UW_W  = 16;
   localparam int FLD_W = 8;

   typedef enum logic [1:0] {
      CLS_ALU = 2'b00,
      CLS_BRC = 2'b01,
      CLS_JMP = 2'b10,
      CLS_HLT = 2'b11
   } cls_e;

   typedef enum logic [1:0] {
      CND_ONE = 2'b00,
      CND_Z   = 2'b01,
      CND_C   = 2'b10,
      CND_N   = 2'b11
   } cnd_e;

   localparam logic [2:0] OP_PASS = 3'd0;
   localparam logic [2:0] OP_ADD  = 3'd1;
   localparam logic [2:0] OP_SUB  = 3'd2;
   localparam logic [2:0] OP_AND  = 3'd3;
   localparam logic [2:0] OP_OR   = 3'd4;
   localparam logic [2:0] OP_XOR  = 3'd5;

   typedef struct packed {
      cls_e             cls;
      cnd_e             cnd;
      logic [2:0]       op;
      logic             src_imm;
      logic [FLD_W-1:0] fld;
   } uword_t;

   typedef struct packed {
      logic n;
      logic c;
      logic z;
   } flags_t;

endpackage

// File: rtl/mcu_ustore.sv
module mcu_ustore
   import mcu_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [UW_W-1:0]   wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [UW_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [UW_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/mcu_useq.sv
module mcu_useq
   import mcu_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  cls_e              cls,
   input  cnd_e              cnd,
   input  logic [ADDR_W-1:0] target,
   input  flags_t            flags,
   output logic [ADDR_W-1:0] pc
);
   if (ADDR_W < 1 || ADDR_W > FLD_W) begin : g_bad_addr_w
      $error("mcu_useq: ADDR_W must lie in 1..FLD_W");
   end

   logic              cond_ok;
   logic [ADDR_W-1:0] pc_nxt;

   always_comb begin
      unique case (cnd)
         CND_ONE: cond_ok = 1'b1;
         CND_Z:   cond_ok = flags.z;
         CND_C:   cond_ok = flags.c;
         default: cond_ok = flags.n;
      endcase
   end

   always_comb begin
      unique case (cls)
         CLS_ALU: pc_nxt = pc + 1'b1;
         CLS_BRC: pc_nxt = cond_ok ? target : pc + 1'b1;
         CLS_JMP: pc_nxt = target;
         default: pc_nxt = pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)        pc <= '0;
      else if (!hold) pc <= pc_nxt;
   end

   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      (!hold && cls == CLS_ALU) |=> pc == ADDR_W'($past(pc) + 1'b1));
   p_jump_r4: assert property (@(posedge clk) disable iff (rst)
      (!hold && cls == CLS_JMP) |=> pc == $past(target));
   p_halt_r6: assert property (@(posedge clk) disable iff (rst)
      (!hold && cls == CLS_HLT) |=> $stable(pc));
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      hold |=> $stable(pc));

endmodule

// File: rtl/mcu_exec.sv
module mcu_exec
   import mcu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit SUB_BORROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  cls_e              cls,
   input  logic [2:0]        op,
   input  logic              src_imm,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] ext,
   output logic [DATA_W-1:0] acc,
   output flags_t            flags
);
   if (DATA_W < 1 || DATA_W > FLD_W) begin : g_bad_data_w
      $error("mcu_exec: DATA_W must lie in 1..FLD_W");
   end

   logic [DATA_W-1:0] opnd;
   logic [DATA_W:0]   sum;
   logic [DATA_W:0]   diff;
   logic [DATA_W-1:0] res;
   logic              sub_cy;
   logic              cy_upd;
   logic              cy_val;
   logic              do_alu;

   assign opnd   = src_imm ? imm : ext;
   assign sum    = {1'b0, acc} + {1'b0, opnd};
   assign diff   = {1'b0, acc} - {1'b0, opnd};
   assign do_alu = !hold && (cls == CLS_ALU);

   if (SUB_BORROW) begin : g_cy_borrow
      assign sub_cy = diff[DATA_W];
   end else begin : g_cy_notborrow
      assign sub_cy = ~diff[DATA_W];
   end

   always_comb begin
      cy_upd = 1'b0;
      cy_val = 1'b0;
      unique case (op)
         OP_ADD: begin res = sum[DATA_W-1:0];  cy_upd = 1'b1; cy_val = sum[DATA_W]; end
         OP_SUB: begin res = diff[DATA_W-1:0]; cy_upd = 1'b1; cy_val = sub_cy;     end
         OP_AND:  res = acc & opnd;
         OP_OR:   res = acc | opnd;
         OP_XOR:  res = acc ^ opnd;
         default: res = opnd;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc   <= '0;
         flags <= '0;
      end else if (do_alu) begin
         acc     <= res;
         flags.z <= (res == '0);
         flags.n <= res[DATA_W-1];
         if (cy_upd) flags.c <= cy_val;
      end
   end

   p_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (!hold && (cls == CLS_BRC || cls == CLS_JMP)) |=> ($stable(acc) && $stable(flags)));
   p_carry_r10: assert property (@(posedge clk) disable iff (rst)
      (do_alu && op != OP_ADD && op != OP_SUB) |=> $stable(flags.c));
   p_zero_r10: assert property (@(posedge clk) disable iff (rst)
      do_alu |=> (flags.z == (acc == '0)) && (flags.n == acc[DATA_W-1]));
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      hold |=> ($stable(acc) && $stable(flags)));

endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
   import mcu_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter bit SUB_BORROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ucode_we,
   input  logic [ADDR_W-1:0] ucode_addr,
   input  logic [UW_W-1:0]   ucode_data,
   input  logic [DATA_W-1:0] opnd_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              zero_o,
   output logic              carry_o,
   output logic              neg_o,
   output logic [ADDR_W-1:0] upc_o
);
   logic [UW_W-1:0]   uw_raw;
   uword_t            uw;
   flags_t            flags;
   logic [ADDR_W-1:0] pc;

   assign uw = uword_t'(uw_raw);

   mcu_ustore #(.ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .we    (ucode_we),
      .waddr (ucode_addr),
      .wdata (ucode_data),
      .raddr (pc),
      .rdata (uw_raw)
   );

   mcu_useq #(.ADDR_W(ADDR_W)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .hold   (ucode_we),
      .cls    (uw.cls),
      .cnd    (uw.cnd),
      .target (uw.fld[ADDR_W-1:0]),
      .flags  (flags),
      .pc     (pc)
   );

   mcu_exec #(.DATA_W(DATA_W), .SUB_BORROW(SUB_BORROW)) u_exec (
      .clk     (clk),
      .rst     (rst),
      .hold    (ucode_we),
      .cls     (uw.cls),
      .op      (uw.op),
      .src_imm (uw.src_imm),
      .imm     (uw.fld[DATA_W-1:0]),
      .ext     (opnd_i),
      .acc     (acc_o),
      .flags   (flags)
   );

   assign zero_o  = flags.z;
   assign carry_o = flags.c;
   assign neg_o   = flags.n;
   assign upc_o   = pc;

endmodule

// File: tb/mcu_ctrl_bench.sv
module mcu_ctrl_bench;
   localparam int PERIOD = 10;
   localparam int NROW   = 18;

   // {addr, word, operand, next addr, acc after, {n,c,z} after}
   localparam logic [50:0] VEC [NROW] = '{
      {8'h00, 16'h0100, 8'h00, 8'h01, 8'h00, 3'b001},
      {8'h01, 16'h5005, 8'h00, 8'h05, 8'h00, 3'b001},
      {8'h05, 16'h0200, 8'hF0, 8'h06, 8'hF0, 3'b100},
      {8'h06, 16'h5010, 8'h00, 8'h07, 8'hF0, 3'b100},
      {8'h07, 16'h0320, 8'h00, 8'h08, 8'h10, 3'b010},
      {8'h08, 16'h6020, 8'h00, 8'h20, 8'h10, 3'b010},
      {8'h20, 16'h0530, 8'h00, 8'h21, 8'hE0, 3'b110},
      {8'h21, 16'h0600, 8'h0F, 8'h22, 8'h00, 3'b011},
      {8'h22, 16'h7040, 8'h00, 8'h23, 8'h00, 3'b011},
      {8'h23, 16'h0981, 8'h00, 8'h24, 8'h81, 3'b110},
      {8'h24, 16'h7030, 8'h00, 8'h30, 8'h81, 3'b110},
      {8'h30, 16'h0A00, 8'hFF, 8'h31, 8'h7E, 3'b010},
      {8'h31, 16'h0400, 8'h7E, 8'h32, 8'h00, 3'b001},
      {8'h32, 16'h4050, 8'h00, 8'h50, 8'h00, 3'b001},
      {8'h50, 16'hA060, 8'h00, 8'h60, 8'h00, 3'b001},
      {8'h60, 16'h0000, 8'h55, 8'h61, 8'h55, 3'b000},
      {8'h61, 16'h0200, 8'hAB, 8'h62, 8'h00, 3'b011},
      {8'h62, 16'hC000, 8'h00, 8'h62, 8'h00, 3'b011}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ucode_we = 1'b0;
   logic [7:0]  ucode_addr = '0;
   logic [15:0] ucode_data = '0;
   logic [7:0]  opnd_i = '0;
   logic [7:0]  acc_o;
   logic        zero_o, carry_o, neg_o;
   logic [7:0]  upc_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   mcu_ctrl u_mcu_ctrl (
      .clk(clk), .rst(rst), .ucode_we(ucode_we), .ucode_addr(ucode_addr),
      .ucode_data(ucode_data), .opnd_i(opnd_i), .acc_o(acc_o),
      .zero_o(zero_o), .carry_o(carry_o), .neg_o(neg_o), .upc_o(upc_o)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_state(input string tag, input logic [7:0] pc, input logic [7:0] acc,
                            input logic [2:0] nzc);
      chk({tag, " pc"}, 16'(upc_o), 16'(pc));
      chk({tag, " acc"}, 16'(acc_o), 16'(acc));
      chk({tag, " flags"}, 16'({neg_o, carry_o, zero_o}), 16'(nzc));
   endtask

   initial begin
      // load the program while reset is held
      for (int i = 0; i < NROW; i++) begin
         ucode_we   = 1'b1;
         ucode_addr = VEC[i][50:43];
         ucode_data = VEC[i][42:27];
         step();
      end
      ucode_we = 1'b0;
      step();
      chk_state("R1 reset", 8'h00, 8'h00, 3'b000);
      rst = 1'b0;

      // walk the vector table
      for (int i = 0; i < NROW; i++) begin
         logic [1:0] cls;
         string      pt, dt;
         cls = VEC[i][42:41];
         case (cls)
            2'b00:   begin pt = "R2"; dt = "R9/R10"; end
            2'b01:   begin pt = "R3"; dt = "R5"; end
            2'b10:   begin pt = "R4"; dt = "R5"; end
            default: begin pt = "R6"; dt = "R6"; end
         endcase
         chk({pt, " fetch addr"}, 16'(upc_o), 16'(VEC[i][50:43]));
         opnd_i = VEC[i][26:19];
         step();
         chk({pt, " next addr"}, 16'(upc_o), 16'(VEC[i][18:11]));
         chk({dt, " acc"}, 16'(acc_o), 16'(VEC[i][10:3]));
         chk({dt, " flags"}, 16'({neg_o, carry_o, zero_o}), 16'(VEC[i][2:0]));
      end

      // R6: halt persists
      for (int k = 0; k < 3; k++) begin
         step();
         chk_state("R6 halt", 8'h62, 8'h00, 3'b011);
      end

      // R7: execution frozen while writing
      ucode_we = 1'b1;
      ucode_addr = 8'h62; ucode_data = 16'h013C; step();
      chk_state("R7 hold", 8'h62, 8'h00, 3'b011);
      ucode_addr = 8'h63; ucode_data = 16'h80FF; step();
      chk_state("R7 hold", 8'h62, 8'h00, 3'b011);
      ucode_addr = 8'hFF; ucode_data = 16'h0101; step();
      chk_state("R7 hold", 8'h62, 8'h00, 3'b011);
      ucode_we = 1'b0;

      // R8: rewritten word runs
      step();
      chk_state("R8 new word", 8'h63, 8'h3C, 3'b010);
      step();
      chk("R4 jump to top", 16'(upc_o), 16'h00FF);
      step();
      chk_state("R2 wrap", 8'h00, 8'h01, 3'b010);

      // R1: reset mid-run
      step();
      rst = 1'b1;
      step();
      chk_state("R1 reset again", 8'h00, 8'h00, 3'b000);
      rst = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule